// File: doc/BRIEF.md
# Coprocessor Command Channel Port

This block connects a processor's custom-instruction unit to a set of command channels. Each channel leads to an accelerator or a peer core. Software builds a command of one or more 32-bit words in a per-channel staging buffer, one word per operation. The channel and the word slot are chosen by the operation's queue ID and index fields. Software then polls the channel with a ready query until the answer is yes. A final push operation copies the whole staged command into a one-entry holding register, which drives the channel's valid/ready request bus.

In the other direction, each channel's response words land in a small FIFO. A pop operation drains that FIFO one word at a time. Each channel has its own command length, given in whole 32-bit words by a parameter. The default build has three channels of 3, 1 and 1 words.

Every operation presented on the operation port gets one registered result. The result carries a valid strobe, a flag and a 32-bit data word.

Top module: `cmdq_port`

## Requirements
- R1: A write operation (kind 0) with index i below the channel's word count stores its data as word i. On the request bus that word occupies bits [32i+31:32i] of the channel's slice, so a multi-word command arrives in index order.
- R2: A write whose index is at or above the channel's word count changes nothing that a later push can send.
- R3: A query operation (kind 1) returns flag = 1 exactly when the channel's holding register is empty or its target asserts ready in the same cycle as the query. The result is due in the cycle after the operation, with data 0.
- R4: An accepted push (kind 2) raises request valid in the next cycle. The command stays on the bus unchanged until the target takes it. Each accepted push makes exactly one transfer.
- R5: A push issued while the channel's flag is low is dropped. It returns flag 0 and sets that channel's sticky error bit, which only a clear operation (kind 4) on that channel resets.
- R6: After a push, the staging buffer may be rewritten at once without altering the command still waiting on the request bus.
- R7: Each channel accepts up to 4 response words and holds response ready low while its FIFO is full.
- R8: A pop operation (kind 3) returns the oldest stored response word with flag 1. On an empty FIFO it returns flag 0 and data 0.
- R9: An operation with a queue ID at or above the channel count changes no state and returns flag 0 and data 0. A result strobe follows every operation, one cycle later.
- R10: After reset, no request is valid, all error bits and staged words are zero, every response FIFO is empty with response ready high, and no result strobe is present.
- R11: The request-data bits above a channel's own word count are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 3 | 0 write, 1 query, 2 push, 3 pop, 4 clear error |
| op_qid | input | QID_W | Target channel |
| op_idx | input | IDX_W | Word index for writes |
| op_wdata | input | 32 | Data word for writes |
| res_valid | output | 1 | Result strobe, one cycle after an operation |
| res_flag | output | 1 | Ready, accepted or pop-valid flag |
| res_data | output | 32 | Popped response word, else 0 |
| err_sticky | output | NUM_CH | Per-channel dropped-push flag |
| req_valid | output | NUM_CH | Request valid per channel |
| req_ready | input | NUM_CH | Request ready per channel |
| req_data | output | NUM_CH*MAX_WORDS*32 | Command per channel, MAX_WORDS*32 bits each |
| rsp_valid | input | NUM_CH | Response valid per channel |
| rsp_ready | output | NUM_CH | Response ready per channel (FIFO not full) |
| rsp_data | input | NUM_CH*32 | Response word per channel |

## Verification
Every stateful result of this block becomes visible one clock edge after its cause. The operation result, a new request valid after an accepted push, the error bit, the response ready change and the drop of request valid after a transfer all follow this rule. The bench presents every stimulus on the falling edge and advances a cycle model of the requirements by one step for that stimulus. After the next rising edge it compares all outputs on the following falling edge. Transfers are counted at rising edges and compared with the number of accepted pushes, so one transfer per push is checked.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        OP_WRITE = 3'd0,
        OP_QUERY = 3'd1,
        OP_PUSH  = 3'd2,
        OP_POP   = 3'd3,
        OP_CLEAR = 3'd4
    } op_kind_e;

    typedef struct packed {
        logic              valid;
        logic              flag;
        logic [WORD_W-1:0] data;
    } result_t;

    // word count of channel c from a vector of 4-bit fields
    function automatic int words_of(input logic [63:0] fields, input int c);
        return int'(fields[c*4 +: 4]);
    endfunction

endpackage

// File: rtl/cmdq_stage.sv
module cmdq_stage
    import cmdq_pkg::*;
#(
    parameter int MAX_WORDS = 3,
    parameter int NWORDS    = 3,
    parameter int IDX_W     = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [WORD_W-1:0]           wr_data,
    input  logic                        push_en,
    input  logic                        clr_en,
    output logic                        can_take,
    output logic                        req_valid,
    input  logic                        req_ready,
    output logic [MAX_WORDS*WORD_W-1:0] req_data,
    output logic                        err
);

    logic [MAX_WORDS-1:0][WORD_W-1:0] stage_q;
    logic [MAX_WORDS-1:0][WORD_W-1:0] hold_q;
    logic                             hold_v;

    // staged words exist only below the channel's word count
    for (genvar w = 0; w < MAX_WORDS; w++) begin : g_word
        if (w < NWORDS) begin : g_live
            always_ff @(posedge clk) begin
                if (rst)
                    stage_q[w] <= '0;
                else if (wr_en && wr_idx == IDX_W'(w))
                    stage_q[w] <= wr_data;
            end
        end else begin : g_tied
            assign stage_q[w] = '0;
        end
    end

    assign can_take = !hold_v || req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v <= 1'b0;
            hold_q <= '0;
        end else if (push_en && can_take) begin
            hold_v <= 1'b1;
            hold_q <= stage_q;
        end else if (hold_v && req_ready) begin
            hold_v <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            err <= 1'b0;
        else if (clr_en)
            err <= 1'b0;
        else if (push_en && !can_take)
            err <= 1'b1;
    end

    assign req_valid = hold_v;
    assign req_data  = hold_q;

    // R4: a waiting command stays put until taken
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_data));

    // R5: dropped push raises the sticky error
    a_r5_drop_sets_err: assert property (@(posedge clk) disable iff (rst)
        push_en && !can_take |=> err);

    // R4: accepted push presents a request next cycle
    a_r4_push_valid: assert property (@(posedge clk) disable iff (rst)
        push_en && can_take |=> req_valid);

endmodule

// File: rtl/cmdq_rsp_fifo.sv
module cmdq_rsp_fifo
    import cmdq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              pop,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DEPTH-1:0][WORD_W-1:0] mem_q;
    logic [AW-1:0]                rp_q, wp_q;
    logic [CW-1:0]                cnt_q;
    logic                         do_wr, do_rd;

    assign in_ready  = cnt_q != CW'(DEPTH);
    assign out_valid = cnt_q != '0;
    assign out_data  = mem_q[rp_q];
    assign do_wr     = in_valid && in_ready;
    assign do_rd     = pop && out_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            rp_q  <= '0;
            wp_q  <= '0;
            cnt_q <= '0;
            mem_q <= '0;
        end else begin
            if (do_wr) begin
                mem_q[wp_q] <= in_data;
                wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            end
            if (do_rd)
                rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            cnt_q <= cnt_q + CW'(do_wr) - CW'(do_rd);
        end
    end

    // R7: occupancy never exceeds the depth
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    // R7: an accepted word leaves the FIFO non-empty
    a_r7_word_kept: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid);

endmodule

// File: rtl/cmdq_port.sv
module cmdq_port
    import cmdq_pkg::*;
#(
    parameter int          NUM_CH    = 3,
    parameter int          MAX_WORDS = 3,
    parameter logic [63:0] CH_WORDS  = 64'h113,
    parameter int          QID_W     = 2,
    parameter int          IDX_W     = 4,
    parameter int          RSP_DEPTH = 4
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               op_valid,
    input  logic [2:0]                         op_kind,
    input  logic [QID_W-1:0]                   op_qid,
    input  logic [IDX_W-1:0]                   op_idx,
    input  logic [31:0]                        op_wdata,
    output logic                               res_valid,
    output logic                               res_flag,
    output logic [31:0]                        res_data,
    output logic [NUM_CH-1:0]                  err_sticky,
    output logic [NUM_CH-1:0]                  req_valid,
    input  logic [NUM_CH-1:0]                  req_ready,
    output logic [NUM_CH*MAX_WORDS*32-1:0]     req_data,
    input  logic [NUM_CH-1:0]                  rsp_valid,
    output logic [NUM_CH-1:0]                  rsp_ready,
    input  logic [NUM_CH*32-1:0]               rsp_data
);

    localparam int SLICE_W = MAX_WORDS * WORD_W;

    op_kind_e                       kind;
    logic                           qid_ok;
    logic [NUM_CH-1:0]              sel, can_take, fifo_v;
    logic [NUM_CH-1:0][WORD_W-1:0]  fifo_d;
    result_t                        res_d, res_q;

    assign kind   = op_kind_e'(op_kind);
    assign qid_ok = int'(op_qid) < NUM_CH;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign sel[c] = op_valid && op_qid == QID_W'(c);

        cmdq_stage #(
            .MAX_WORDS (MAX_WORDS),
            .NWORDS    (words_of(CH_WORDS, c)),
            .IDX_W     (IDX_W)
        ) u_stage (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (sel[c] && kind == OP_WRITE),
            .wr_idx    (op_idx),
            .wr_data   (op_wdata),
            .push_en   (sel[c] && kind == OP_PUSH),
            .clr_en    (sel[c] && kind == OP_CLEAR),
            .can_take  (can_take[c]),
            .req_valid (req_valid[c]),
            .req_ready (req_ready[c]),
            .req_data  (req_data[c*SLICE_W +: SLICE_W]),
            .err       (err_sticky[c])
        );

        cmdq_rsp_fifo #(
            .DEPTH     (RSP_DEPTH)
        ) u_rsp (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (rsp_valid[c]),
            .in_ready  (rsp_ready[c]),
            .in_data   (rsp_data[c*WORD_W +: WORD_W]),
            .pop       (sel[c] && kind == OP_POP),
            .out_valid (fifo_v[c]),
            .out_data  (fifo_d[c])
        );
    end

    always_comb begin
        res_d       = '0;
        res_d.valid = op_valid;
        for (int c = 0; c < NUM_CH; c++) begin
            if (sel[c]) begin
                unique case (kind)
                    OP_QUERY, OP_PUSH: res_d.flag = can_take[c];
                    OP_POP: begin
                        res_d.flag = fifo_v[c];
                        res_d.data = fifo_v[c] ? fifo_d[c] : '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign res_valid = res_q.valid;
    assign res_flag  = res_q.flag;
    assign res_data  = res_q.data;

    // R9: each operation yields exactly one result strobe
    a_r9_result_strobe: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);

    a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !res_valid);

    // R9: unknown channel gives an empty result
    a_r9_bad_qid: assert property (@(posedge clk) disable iff (rst)
        op_valid && !qid_ok |=> !res_flag && res_data == '0);

    // R8: pop on an empty FIFO returns flag 0
    a_r8_empty_pop: assert property (@(posedge clk) disable iff (rst)
        op_valid && qid_ok && kind == OP_POP && !(|(fifo_v & sel)) |=> !res_flag);

endmodule

// File: tb/tb_cmdq_port.sv
module tb_cmdq_port;

    localparam int NCH = 3;
    localparam int MW  = 3;
    localparam int DW  = NCH * MW * 32;
    localparam int CHW [NCH] = '{3, 1, 1};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              op_valid = 1'b0;
    logic [2:0]        op_kind = '0;
    logic [1:0]        op_qid = '0;
    logic [3:0]        op_idx = '0;
    logic [31:0]       op_wdata = '0;
    logic              res_valid, res_flag;
    logic [31:0]       res_data;
    logic [NCH-1:0]    err_sticky, req_valid, rsp_ready;
    logic [NCH-1:0]    req_ready = '0;
    logic [NCH-1:0]    rsp_valid = '0;
    logic [DW-1:0]     req_data;
    logic [NCH*32-1:0] rsp_data = '0;

    always #5 clk = ~clk;

    cmdq_port dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .op_qid(op_qid), .op_idx(op_idx), .op_wdata(op_wdata),
        .res_valid(res_valid), .res_flag(res_flag), .res_data(res_data),
        .err_sticky(err_sticky), .req_valid(req_valid), .req_ready(req_ready),
        .req_data(req_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data(rsp_data)
    );

    int checks = 0;
    int fails  = 0;

    // cycle model of the requirements
    logic [31:0] m_stg [NCH][MW];
    logic [31:0] m_hd  [NCH][MW];
    logic        m_hv  [NCH];
    logic        m_err [NCH];
    logic [31:0] m_fq  [NCH][4];
    int          m_fc  [NCH];
    logic        m_rv, m_rf;
    logic [31:0] m_rd;
    string       m_tag;
    int          m_xfer = 0;
    int          dut_xfer = 0;

    always @(posedge clk)
        if (!rst)
            for (int c = 0; c < NCH; c++)
                if (req_valid[c] && req_ready[c]) dut_xfer++;

    task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] exp_req();
        logic [DW-1:0] v = '0;
        for (int c = 0; c < NCH; c++)
            for (int w = 0; w < MW; w++)
                v[(c*MW + w)*32 +: 32] = m_hd[c][w];
        return v;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_hv[c] = 0; m_err[c] = 0; m_fc[c] = 0;
            for (int w = 0; w < MW; w++) begin m_stg[c][w] = '0; m_hd[c][w] = '0; end
            for (int i = 0; i < 4; i++) m_fq[c][i] = '0;
        end
        m_rv = 0; m_rf = 0; m_rd = '0; m_tag = "R10";
    endtask

    task automatic compare();
        logic [NCH-1:0] ev, ee, er;
        for (int c = 0; c < NCH; c++) begin
            ev[c] = m_hv[c]; ee[c] = m_err[c]; er[c] = m_fc[c] < 4;
        end
        chk("R4 req_valid", DW'(req_valid), DW'(ev));
        chk("R1 req_data", req_data, exp_req());
        chk("R5 err_sticky", DW'(err_sticky), DW'(ee));
        chk("R7 rsp_ready", DW'(rsp_ready), DW'(er));
        chk("R9 res_valid", DW'(res_valid), DW'(m_rv));
        chk({m_tag, " res_flag"}, DW'(res_flag), DW'(m_rf));
        chk({m_tag, " res_data"}, DW'(res_data), DW'(m_rd));
    endtask

    task automatic step(input bit v, input int k, input int q, input int ix, input logic [31:0] d);
        logic ct [NCH];
        bit ok;
        op_valid = v; op_kind = 3'(k); op_qid = 2'(q); op_idx = 4'(ix); op_wdata = d;
        ok = v && q < NCH;
        for (int c = 0; c < NCH; c++) ct[c] = !m_hv[c] || req_ready[c];
        m_rv = v; m_rf = 0; m_rd = '0;
        m_tag = !v ? "R9" : (!ok ? "R9" : (k == 3 ? "R8" : (k == 2 ? "R5" : "R3")));
        if (ok) begin
            if (k == 1 || k == 2) m_rf = ct[q];
            if (k == 3 && m_fc[q] > 0) begin m_rf = 1; m_rd = m_fq[q][0]; end
        end
        for (int c = 0; c < NCH; c++) begin
            bit me = ok && q == c;
            if (m_hv[c] && req_ready[c]) m_xfer++;
            if (me && k == 2 && ct[c]) begin
                m_hv[c] = 1;
                for (int w = 0; w < MW; w++) m_hd[c][w] = m_stg[c][w];
            end else if (m_hv[c] && req_ready[c]) m_hv[c] = 0;
            if (me && k == 4) m_err[c] = 0;
            else if (me && k == 2 && !ct[c]) m_err[c] = 1;
            if (me && k == 0 && ix < CHW[c]) m_stg[c][ix] = d;
            begin
                bit acc = rsp_valid[c] && m_fc[c] < 4;
                if (me && k == 3 && m_fc[c] > 0) begin
                    for (int i = 0; i < 3; i++) m_fq[c][i] = m_fq[c][i+1];
                    m_fc[c]--;
                end
                if (acc) begin m_fq[c][m_fc[c]] = rsp_data[c*32 +: 32]; m_fc[c]++; end
            end
        end
        @(posedge clk); @(negedge clk);
        compare();
    endtask

    task automatic idle();
        step(0, 0, 0, 0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        compare(); // R10 reset state
        chk("R10 rsp_ready", DW'(rsp_ready), DW'(3'b111));

        // R1: three-word command, target stalled
        step(1, 0, 0, 0, 32'hA0A0_0001);
        step(1, 0, 0, 1, 32'hB0B0_0002);
        step(1, 0, 0, 2, 32'hC0C0_0003);
        // R2: out-of-range indices
        step(1, 0, 0, 3, 32'hDEAD_0000);
        step(1, 0, 1, 5, 32'hDEAD_0001);
        step(1, 0, 1, 0, 32'h1111_1111);
        step(1, 1, 0, 0, '0);
        chk("R3 query empty", DW'(res_flag), DW'(1));
        step(1, 2, 0, 0, '0);
        step(1, 2, 1, 0, '0);
        idle();
        chk("R1 word order", DW'(req_data[95:0]), DW'({32'hC0C0_0003, 32'hB0B0_0002, 32'hA0A0_0001}));
        chk("R2 ignored index", DW'(req_data[191:96]), DW'({32'h0, 32'h0, 32'h1111_1111}));
        chk("R11 upper zero", DW'(req_data[287:192]), '0);
        // R6: overwrite staging while command waits
        step(1, 0, 0, 0, 32'h5555_5555);
        chk("R6 in flight kept", DW'(req_data[31:0]), DW'(32'hA0A0_0001));
        // R5: push while full and stalled
        step(1, 1, 0, 0, '0);
        chk("R3 query busy", DW'(res_flag), DW'(0));
        step(1, 2, 0, 0, '0);
        chk("R5 drop err", DW'(err_sticky[0]), DW'(1));
        step(1, 4, 0, 0, '0);
        chk("R5 cleared", DW'(err_sticky[0]), DW'(0));
        // R4: release target, one transfer each
        req_ready = 3'b011;
        idle(); idle();
        req_ready = '0;
        // R7: fill channel 2 FIFO
        rsp_valid = 3'b100;
        for (int i = 0; i < 6; i++) begin
            rsp_data[64 +: 32] = 32'h7000_0000 + 32'(i);
            idle();
        end
        chk("R7 full", DW'(rsp_ready[2]), DW'(0));
        rsp_valid = '0;
        step(1, 3, 2, 0, '0);
        chk("R8 oldest", DW'(res_data), DW'(32'h7000_0000));
        for (int i = 0; i < 4; i++) step(1, 3, 2, 0, '0);
        chk("R8 empty pop", DW'(res_flag), DW'(0));
        // R9: invalid channel
        step(1, 2, 3, 0, '0);
        chk("R9 bad qid", DW'(res_flag), DW'(0));

        // random phase
        for (int n = 0; n < 4000; n++) begin
            for (int c = 0; c < NCH; c++) begin
                req_ready[c] = ($urandom % 10) < 4;
                rsp_valid[c] = ($urandom % 10) < 3;
                rsp_data[c*32 +: 32] = $urandom;
            end
            step(($urandom % 4) != 0, int'($urandom % 5), int'($urandom % 4),
                 int'($urandom % 5), $urandom);
        end
        req_ready = '1; rsp_valid = '0;
        idle(); idle();
        chk("R4 one transfer per push", DW'(dut_xfer), DW'(m_xfer));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule